// File: doc/BRIEF.md
# Corrected-Error Threshold Interrupt Bank

This block holds a set of error-reporting banks, each counting the corrected errors reported to it on a one-cycle pulse input. Software programs a threshold per bank. When a new error brings a bank's count up to exactly that threshold while the bank's interrupt is enabled, the block marks the bank as pending. It also raises an interrupt request toward every logical processor that the static sharing mask associates with that bank. Each request line is sticky and feeds the corrected-error entry of that processor's local interrupt controller.

Software reaches the banks through one word-wide register port. One address is shared for writing and for the combinational read data. Address 0x00 reports how many banks exist. Address 0x01 shows the request lines and takes per-processor acknowledge writes. Bank i occupies two words: a control word at 0x10+2i and a status word at 0x11+2i. The control word's enable bit also acts as an ownership flag. When several processors share a bank, the first one to set the bit owns the bank, and the others read the bit set and move on to the next bank. Only the corrected-error pulses advance the counts. Nothing else can raise a request.

Top module: `cet_irq_bank`

## Requirements
- R1: After reset every request line is 0 and every control and status word reads 0.
- R2: Address 0x00 reads the bank count in bits 7:0 and zero elsewhere, and writes to it are ignored.
- R3: The control word of bank i (address 0x10+2i) stores the threshold in bits 14:0 and the enable/ownership flag in bit 30; all other bits read 0.
- R4: Each cycle that ce_pulse[i] is high raises the count of bank i (status bits 52:38) by one, visible in the following cycle.
- R5: The count stops at 0x7FFF; a pulse that arrives while the count is 0x7FFF leaves it unchanged.
- R6: When a pulse raises the count of bank i to a value equal to its threshold while the enable bit (as held before that edge) is 1, status bit 63 of that bank becomes 1. In the same cycle, irq_req[p] becomes 1 for every p with share_mask[i*NCPU+p]=1. The block raises no request when the enable bit is 0 or when the count only passes the threshold.
- R7: A threshold of 0 behaves exactly as a threshold of 1.
- R8: irq_req[p] stays 1 until a write to address 0x01 with bit p set clears it; address 0x01 reads the request lines in bits NCPU-1:0. A new event in the same cycle as the acknowledge wins, and the line stays 1.
- R9: A status write loads the count from bits 52:38. When the loaded value is 0, it also clears the pending bit 63. A pulse in the same cycle as the status write is dropped.
- R10: Addresses of banks at or beyond the bank count, and all other unused addresses, read 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | AW | Word address for write and read |
| reg_wdata | input | 64 | Write data |
| rd_data | output | 64 | Read data for reg_addr (combinational) |
| ce_pulse | input | NBANK | Corrected-error pulse, one per bank |
| share_mask | input | NBANK*NCPU | Bit i*NCPU+p routes bank i to processor p |
| irq_req | output | NCPU | Sticky interrupt request per processor |

## Verification
The bench targets the exact-equality trigger. It drives counts through the threshold and beyond it, where a greater-or-equal comparator would re-fire on every later error, and it sets a zero threshold that a literal comparator would never match. It holds a bank at 0x7FFF and keeps pulsing, so a wrapping counter would show 0 and then re-fire. It lands an acknowledge on the same cycle as a fresh event, and a status write on the same cycle as a pulse, to catch wrong priorities. It writes to unimplemented bank addresses, where an aliasing decoder would corrupt a real bank. It routes banks to overlapping and empty processor sets, so a fan-out to the wrong lines shows up as a request on an unshared processor.

// File: rtl/cet_irq_bank.sv
module cet_irq_bank #(
  parameter int NBANK = 4,
  parameter int NCPU  = 4,
  parameter int AW    = 8,
  parameter int CW    = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [AW-1:0]         reg_addr,
  input  logic [63:0]           reg_wdata,
  output logic [63:0]           rd_data,
  input  logic [NBANK-1:0]      ce_pulse,
  input  logic [NBANK*NCPU-1:0] share_mask,
  output logic [NCPU-1:0]       irq_req
);
  localparam int CAP_ADDR = 0;
  localparam int ACK_ADDR = 1;
  localparam int BASE     = 16;
  localparam int EN_BIT   = 30;
  localparam int CNT_LO   = 38;
  localparam int CNT_HI   = CNT_LO + CW - 1;
  localparam int PEND_BIT = 63;

  logic [NBANK-1:0][CW-1:0] thr_q;
  logic [NBANK-1:0][CW-1:0] cnt_q;
  logic [NBANK-1:0]         en_q;
  logic [NBANK-1:0]         pend_q;
  logic [NBANK-1:0]         fire;
  logic [NCPU-1:0]          hit;
  logic [NCPU-1:0]          ack;
  logic                     unused_bits;

  assign unused_bits = ^reg_wdata;
  assign ack = (reg_we && reg_addr == AW'(ACK_ADDR)) ? reg_wdata[NCPU-1:0] : '0;

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    localparam int CA = BASE + 2 * i;
    logic          ctl_wr, sts_wr, bump;
    logic [CW-1:0] eff_thr, nxt;

    assign ctl_wr  = reg_we && reg_addr == AW'(CA);
    assign sts_wr  = reg_we && reg_addr == AW'(CA + 1);
    assign eff_thr = (thr_q[i] == '0) ? CW'(1) : thr_q[i];
    assign nxt     = cnt_q[i] + CW'(1);
    assign bump    = ce_pulse[i] && !(&cnt_q[i]) && !sts_wr;
    assign fire[i] = bump && en_q[i] && nxt == eff_thr;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        thr_q[i]  <= '0;
        en_q[i]   <= 1'b0;
        cnt_q[i]  <= '0;
        pend_q[i] <= 1'b0;
      end else begin
        if (ctl_wr) begin
          thr_q[i] <= reg_wdata[CW-1:0];
          en_q[i]  <= reg_wdata[EN_BIT];
        end
        if (sts_wr) begin
          cnt_q[i] <= reg_wdata[CNT_HI:CNT_LO];
          if (reg_wdata[CNT_HI:CNT_LO] == '0) pend_q[i] <= 1'b0;
        end else if (bump) begin
          cnt_q[i] <= nxt;
        end
        if (fire[i]) pend_q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    hit = '0;
    for (int p = 0; p < NCPU; p++)
      for (int i = 0; i < NBANK; i++)
        if (fire[i] && share_mask[i*NCPU+p]) hit[p] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_req <= '0;
    else        irq_req <= hit | (irq_req & ~ack);
  end

  always_comb begin
    rd_data = '0;
    if (reg_addr == AW'(CAP_ADDR)) rd_data[7:0] = 8'(NBANK);
    if (reg_addr == AW'(ACK_ADDR)) rd_data[NCPU-1:0] = irq_req;
    for (int i = 0; i < NBANK; i++) begin
      if (reg_addr == AW'(BASE + 2 * i)) begin
        rd_data[CW-1:0]  = thr_q[i];
        rd_data[EN_BIT]  = en_q[i];
      end
      if (reg_addr == AW'(BASE + 2 * i + 1)) begin
        rd_data[CNT_HI:CNT_LO] = cnt_q[i];
        rd_data[PEND_BIT]      = pend_q[i];
      end
    end
  end
endmodule

// File: rtl/cet_irq_bank_chk.sv
module cet_irq_bank_chk #(
  parameter int NBANK = 4,
  parameter int NCPU  = 4,
  parameter int AW    = 8,
  parameter int CW    = 15
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_we,
  input logic [AW-1:0]            reg_addr,
  input logic [63:0]              reg_wdata,
  input logic [63:0]              rd_data,
  input logic [NBANK-1:0]         ce_pulse,
  input logic [NBANK*NCPU-1:0]    share_mask,
  input logic [NCPU-1:0]          irq_req,
  input logic [NBANK-1:0][CW-1:0] cnt_q
);
  logic [NCPU-1:0] ackv, reach;
  assign ackv = (reg_we && reg_addr == AW'(1)) ? reg_wdata[NCPU-1:0] : '0;

  always_comb begin
    reach = '0;
    for (int p = 0; p < NCPU; p++)
      for (int i = 0; i < NBANK; i++)
        if (ce_pulse[i] && share_mask[i*NCPU+p]) reach[p] = 1'b1;
  end

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(irq_req & ~ackv) |=> ((irq_req & $past(irq_req & ~ackv)) == $past(irq_req & ~ackv)));

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_req & ~$past(irq_req) & ~$past(reach)) == '0));

  // R2
  cap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == AW'(0) |-> rd_data == 64'(NBANK));

  // R10
  unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) >= 16 + 2 * NBANK) |-> rd_data == '0);

  for (genvar i = 0; i < NBANK; i++) begin : g_sat
    // R5
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&cnt_q[i]) && !(reg_we && reg_addr == AW'(16 + 2 * i + 1)) |=> (&cnt_q[i]));
  end
endmodule

bind cet_irq_bank cet_irq_bank_chk #(.NBANK(NBANK), .NCPU(NCPU), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .rd_data(rd_data), .ce_pulse(ce_pulse), .share_mask(share_mask), .irq_req(irq_req),
  .cnt_q(cnt_q));

// File: tb/test_cet_irq_bank.sv
module test_cet_irq_bank;
  localparam int NB = 4, NC = 4, AW = 8, MAXC = 32'h7FFF;

  logic clk = 0, rst_n = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [63:0] wdata = '0, rd_data;
  logic [NB-1:0] ce = '0;
  logic [NB*NC-1:0] mask = '0;
  logic [NC-1:0] irq;

  int thr[NB], en[NB], cnt[NB], pend[NB];
  bit m_irq[NC];
  int n_cmp = 0, n_bad = 0;
  string cur = "R1";

  always #2 clk = ~clk;

  cet_irq_bank #(.NBANK(NB), .NCPU(NC), .AW(AW), .CW(15)) i_cet_irq_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .rd_data(rd_data), .ce_pulse(ce), .share_mask(mask), .irq_req(irq));

  function automatic logic [63:0] m_read(int a);
    logic [63:0] r = '0;
    if (a == 0) r[7:0] = 8'(NB);
    else if (a == 1) for (int p = 0; p < NC; p++) r[p] = m_irq[p];
    else if (a >= 16 && a < 16 + 2 * NB) begin
      int b = (a - 16) / 2;
      if (a % 2 == 0) begin r[14:0] = 15'(thr[b]); r[30] = en[b][0]; end
      else begin r[52:38] = 15'(cnt[b]); r[63] = pend[b][0]; end
    end
    return r;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < NB; i++) begin thr[i] = 0; en[i] = 0; cnt[i] = 0; pend[i] = 0; end
    for (int p = 0; p < NC; p++) m_irq[p] = 0;
  endtask

  task automatic m_step();
    bit fire[NB];
    int a = int'(addr);
    for (int i = 0; i < NB; i++) begin
      bit sw = we && a == 17 + 2 * i;
      int eff = (thr[i] == 0) ? 1 : thr[i];
      bit bump = ce[i] && cnt[i] != MAXC && !sw;
      fire[i] = bump && en[i] != 0 && cnt[i] + 1 == eff;
      if (bump) cnt[i] = cnt[i] + 1;
      if (fire[i]) pend[i] = 1;
    end
    for (int p = 0; p < NC; p++) begin
      bit h = 0;
      for (int i = 0; i < NB; i++) if (fire[i] && mask[i*NC+p]) h = 1;
      if (h) m_irq[p] = 1;
      else if (we && a == 1 && wdata[p]) m_irq[p] = 0;
    end
    if (we) for (int i = 0; i < NB; i++) begin
      if (a == 16 + 2 * i) begin thr[i] = int'(wdata[14:0]); en[i] = int'(wdata[30]); end
      if (a == 17 + 2 * i) begin
        cnt[i] = int'(wdata[52:38]);
        if (cnt[i] == 0) pend[i] = 0;
      end
    end
  endtask

  task automatic compare();
    logic [NC-1:0] ei;
    logic [63:0] er = m_read(int'(addr));
    for (int p = 0; p < NC; p++) ei[p] = m_irq[p];
    n_cmp++;
    if (irq !== ei || rd_data !== er) begin
      n_bad++;
      $display("FAIL %s addr=%0h irq=%b exp=%b rd=%h exp=%h", cur, addr, irq, ei, rd_data, er);
    end
  endtask

  task automatic tick(bit w, int a, logic [63:0] d, logic [NB-1:0] c);
    we = w; addr = AW'(a); wdata = d; ce = c;
    @(posedge clk); #1;
    if (rst_n) m_step(); else m_reset();
    compare();
    @(negedge clk);
  endtask

  task automatic rd(int a); tick(0, a, '0, '0); endtask
  task automatic wr(int a, logic [63:0] d); tick(1, a, d, '0); endtask
  function automatic logic [63:0] cval(int v); return 64'(v) << 38; endfunction

  initial begin
    m_reset();
    @(negedge clk);
    repeat (3) tick(0, 0, '0, '0);
    rst_n = 1;
    cur = "R1"; for (int a = 0; a < 24; a++) rd(a);
    cur = "R2"; wr(0, '1); rd(0);
    cur = "R3"; wr(16, '1); rd(16); wr(18, 64'h0000_0000_4000_1234); rd(18); wr(16, '0); rd(16);
    mask = 16'b0000_1111_0100_0011;
    cur = "R4"; tick(0, 17, '0, 4'b0001); tick(0, 17, '0, 4'b0001); rd(17); wr(17, '0);
    cur = "R6"; wr(16, 64'h4000_0003);
    for (int k = 0; k < 5; k++) tick(0, 17, '0, 4'b0001);
    rd(1);
    cur = "R8"; wr(1, 64'h1); rd(1); wr(1, 64'h2); rd(1);
    wr(17, '0); wr(16, 64'h4000_0001);
    tick(1, 1, 64'hF, 4'b0001); rd(1); wr(1, 64'hF); rd(1);
    cur = "R7"; wr(18, 64'h4000_0000); tick(0, 1, '0, 4'b0010); tick(0, 19, '0, 4'b0010); rd(1);
    cur = "R5"; wr(22, 64'h4000_7FFF); wr(23, cval(MAXC - 2));
    for (int k = 0; k < 4; k++) tick(0, 23, '0, 4'b1000);
    cur = "R9"; wr(17, cval(0)); rd(17); wr(17, cval(5)); rd(17);
    tick(1, 17, cval(0), 4'b0001); rd(17); wr(1, 64'hF);
    cur = "R6"; wr(20, 64'h0000_0002);
    for (int k = 0; k < 3; k++) tick(0, 21, '0, 4'b0100);
    rd(1); wr(21, '0); wr(20, 64'h4000_0002);
    for (int k = 0; k < 3; k++) tick(0, 21, '0, 4'b0100);
    rd(1); wr(1, 64'hF);
    cur = "R10"; wr(24, '1); wr(25, '1); wr(200, '1); rd(24); rd(25); rd(200); rd(16); rd(1);
    cur = "R6";
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 99);
      logic [NB-1:0] c = NB'($urandom);
      if (k % 500 == 0) mask = 16'($urandom);
      if (r < 6) tick(1, 16 + 2 * $urandom_range(0, NB - 1),
                      64'h4000_0000 | 64'($urandom_range(0, 6)), c);
      else if (r < 10) tick(1, 17 + 2 * $urandom_range(0, NB - 1),
                      cval($urandom_range(0, 3) == 0 ? MAXC - 1 : 0), c);
      else if (r < 14) tick(1, 1, 64'($urandom), c);
      else tick(0, $urandom_range(0, 25), '0, c);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog %s expired", cur);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule